// File: doc/BRIEF.md
# Mode-Based Region Access Guard

The guard sits on the request path between the bus masters and the memory and chipset register space. It decides, in the same cycle as the request, whether the access may go through. The decision rests on a two-bit operating mode and on a few address windows. Those windows are a handful of power-of-two-aligned protected regions owned by the supervising system, a pair of chipset register banks (older registers and newer ones), and a small bank of device-control registers whose writes must be handed to the supervisor. The guard also keeps its own small configuration window, which is reached through the same bus.

Allowed accesses see no added latency. A forbidden access is dropped and does nothing. The guard raises a sticky interrupt, records what was attempted, and moves the mode to supervisor, so that the exception handler runs with full rights. A non-supervisor write into the device-control bank is dropped in the same way but raises a wake-up pulse instead of an interrupt. The supervising system sets the mode each time it hands the machine back to the other side.

Top module: `region_guard`

## Requirements
- R1: After reset the mode is supervisor (encoding 2'b10), the interrupt is low, the captured kind is 0 and, with no request, pass_en and wake are low. The mode never holds 2'b11. Legacy is 2'b00 and intermediate is 2'b01.
- R2: The configuration window covers 16 bytes at CFG_BASE (default 24'hFFFF00). Supervisor writes at offset 0 set the mode from wdata[1:0], and a value of 3 is ignored. A write at offset 1 clears the interrupt. A write at offset 8+i loads comparator i with base wdata[23:0], size exponent wdata[28:24] and enable wdata[29]. A configuration access never asserts pass_en.
- R3: Comparator i matches when it is enabled and the address agrees with its base in every bit at or above its size exponent. A disabled comparator never matches. Exponent 0 covers a single byte.
- R4: An access from legacy or intermediate mode that matches any comparator is blocked with kind 2. The supervisor passes.
- R5: The old chipset bank (OLD_BASE, 4 KiB) passes in every mode. An access from legacy mode into the new bank (NEW_BASE, 4 KiB) is blocked with kind 3. Intermediate and supervisor modes pass.
- R6: A non-supervisor write into the device-control bank (TRAP_BASE, 256 bytes, inside the old bank) drops the access, asserts wake in that cycle and leaves the interrupt unchanged. Reads there pass, and supervisor writes there pass without a wake.
- R7: On a blocked access, pass_en is low in that cycle and irq is high from the next cycle on, until it is cleared through R2. The address, write flag, mode and kind of the first violation are captured, and later violations leave them unchanged while irq is high.
- R8: After a violation or a wake, the mode is supervisor from the next cycle on.
- R9: pass_en follows an allowed req_valid in the same cycle. With req_valid low, pass_en and wake are low and no violation is recorded.
- R10: A non-supervisor access to the configuration window is blocked with kind 1 and changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DW | Write data, used for configuration writes |
| pass_en | output | 1 | Forward the request downstream |
| wake | output | 1 | Device-control write trapped for the supervisor |
| cur_mode | output | 2 | Current operating mode |
| irq | output | 1 | Sticky violation interrupt |
| viol_addr | output | AW | Captured address of the first violation |
| viol_write | output | 1 | Captured write flag |
| viol_mode | output | 2 | Mode in force at the violation |
| viol_kind | output | 2 | 1 configuration, 2 protected region, 3 new bank |

## Verification
The hardest state to reach is a second violation that arrives while the first is still pending. Each violation moves the mode to supervisor, where nothing is blocked, so the stimulus has to step the mode back down through the configuration window between the two violations, without clearing the interrupt. The bench does this and then checks that the first capture survived. It uses the same step-down sequence to reach the single-byte comparator edge, and to show that a blocked write into the configuration window from legacy mode left a disabled comparator disabled.

// File: rtl/rgd_pkg.sv
package rgd_pkg;

  typedef enum logic [1:0] {
    MODE_LEG = 2'b00,
    MODE_MID = 2'b01,
    MODE_SUP = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    VK_NONE   = 2'd0,
    VK_CFG    = 2'd1,
    VK_PROT   = 2'd2,
    VK_NEWREG = 2'd3
  } vkind_e;

  // True when addr and base agree in every bit at or above bit lg.
  function automatic logic aligned_hit(input logic [63:0] addr,
                                       input logic [63:0] base,
                                       input logic [6:0]  lg);
    logic [63:0] keep;
    if (lg >= 7'd64) keep = '0;
    else             keep = ~((64'd1 << lg) - 64'd1);
    return ((addr ^ base) & keep) == 64'd0;
  endfunction

  function automatic logic mode_code_ok(input logic [1:0] code);
    return code != 2'b11;
  endfunction

endpackage

// File: rtl/guard_regs.sv
module guard_regs
  import rgd_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int NCMP = 4,
  parameter int EW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_off,
  input  logic [DW-1:0]      cfg_data,
  input  logic               elevate,
  output mode_e              mode_q,
  output logic [AW-1:0]      cmp_base [NCMP],
  output logic [EW-1:0]      cmp_exp  [NCMP],
  output logic [NCMP-1:0]    cmp_en,
  output logic               clr_irq
);

  localparam logic [3:0] OFF_MODE  = 4'd0;
  localparam logic [3:0] OFF_CLEAR = 4'd1;
  localparam int         EN_BIT    = AW + EW;

  logic unused_data_bits;
  assign unused_data_bits = ^cfg_data[DW-1:EN_BIT+1];

  logic mode_wr;
  assign mode_wr = cfg_wr && cfg_off == OFF_MODE && mode_code_ok(cfg_data[1:0]);
  assign clr_irq = cfg_wr && cfg_off == OFF_CLEAR;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_SUP;
    else if (elevate) mode_q <= MODE_SUP;
    else if (mode_wr) mode_q <= mode_e'(cfg_data[1:0]);
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic load;
    assign load = cfg_wr && cfg_off[3] && cfg_off[2:0] == 3'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_base[i] <= '0;
        cmp_exp[i]  <= '0;
        cmp_en[i]   <= 1'b0;
      end else if (load) begin
        cmp_base[i] <= cfg_data[AW-1:0];
        cmp_exp[i]  <= cfg_data[AW+EW-1:AW];
        cmp_en[i]   <= cfg_data[EN_BIT];
      end
    end
  end

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code_ok(mode_q));

  // R8
  elevate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elevate |=> mode_q == MODE_SUP);

endmodule

// File: rtl/guard_decide.sv
module guard_decide
  import rgd_pkg::*;
#(
  parameter int              AW        = 24,
  parameter int              NCMP      = 4,
  parameter int              EW        = 5,
  parameter logic [AW-1:0]   CFG_BASE  = 24'hFFFF00,
  parameter logic [AW-1:0]   OLD_BASE  = 24'hDF0000,
  parameter logic [AW-1:0]   NEW_BASE  = 24'hDF1000,
  parameter logic [AW-1:0]   TRAP_BASE = 24'hDF0400,
  parameter int              BANK_LG   = 12,
  parameter int              TRAP_LG   = 8
) (
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_write,
  input  mode_e              mode,
  input  logic [AW-1:0]      cmp_base [NCMP],
  input  logic [EW-1:0]      cmp_exp  [NCMP],
  input  logic [NCMP-1:0]    cmp_en,
  output logic               cfg_acc,
  output logic               pass,
  output logic               viol,
  output logic               trap,
  output vkind_e             kind,
  output logic               prot_any
);

  localparam logic [6:0] CFG_LG = 7'd4;

  logic [NCMP-1:0] cmp_hit;
  logic            in_cfg, in_old, in_new, in_trap, is_sup;

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign cmp_hit[i] = cmp_en[i] &&
      aligned_hit(64'(req_addr), 64'(cmp_base[i]), 7'(cmp_exp[i]));
  end

  assign prot_any = |cmp_hit;
  assign in_cfg   = aligned_hit(64'(req_addr), 64'(CFG_BASE),  CFG_LG);
  assign in_old   = aligned_hit(64'(req_addr), 64'(OLD_BASE),  7'(BANK_LG));
  assign in_new   = aligned_hit(64'(req_addr), 64'(NEW_BASE),  7'(BANK_LG));
  assign in_trap  = in_old &&
                    aligned_hit(64'(req_addr), 64'(TRAP_BASE), 7'(TRAP_LG));
  assign is_sup   = mode == MODE_SUP;

  always_comb begin
    cfg_acc = 1'b0;
    pass    = 1'b0;
    viol    = 1'b0;
    trap    = 1'b0;
    kind    = VK_NONE;
    if (req_valid) begin
      if (in_cfg) begin
        if (is_sup) cfg_acc = 1'b1;
        else begin
          viol = 1'b1;
          kind = VK_CFG;
        end
      end else if (prot_any && !is_sup) begin
        viol = 1'b1;
        kind = VK_PROT;
      end else if (in_new && mode != MODE_MID && !is_sup) begin
        viol = 1'b1;
        kind = VK_NEWREG;
      end else if (in_trap && req_write && !is_sup) begin
        trap = 1'b1;
      end else begin
        pass = 1'b1;
      end
    end
  end

endmodule

// File: rtl/guard_capture.sv
module guard_capture
  import rgd_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic          clr_irq,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  mode_e         mode,
  input  vkind_e        kind,
  output logic          irq_q,
  output logic [AW-1:0] cap_addr,
  output logic          cap_write,
  output logic [1:0]    cap_mode,
  output logic [1:0]    cap_kind
);

  logic take;
  assign take = viol && !irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (clr_irq) irq_q <= 1'b0;
    else if (viol)    irq_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_mode  <= 2'b00;
      cap_kind  <= 2'b00;
    end else if (take) begin
      cap_addr  <= addr;
      cap_write <= write;
      cap_mode  <= mode;
      cap_kind  <= kind;
    end
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> irq_q);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr_irq |=> irq_q);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr_irq |=> $stable(cap_addr) && $stable(cap_kind));

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rgd_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            DW        = 32,
  parameter int            NCMP      = 4,
  parameter logic [AW-1:0] CFG_BASE  = 24'hFFFF00,
  parameter logic [AW-1:0] OLD_BASE  = 24'hDF0000,
  parameter logic [AW-1:0] NEW_BASE  = 24'hDF1000,
  parameter logic [AW-1:0] TRAP_BASE = 24'hDF0400,
  parameter int            BANK_LG   = 12,
  parameter int            TRAP_LG   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          pass_en,
  output logic          wake,
  output logic [1:0]    cur_mode,
  output logic          irq,
  output logic [AW-1:0] viol_addr,
  output logic          viol_write,
  output logic [1:0]    viol_mode,
  output logic [1:0]    viol_kind
);

  localparam int EW = $clog2(AW + 1);

  mode_e           mode_q;
  logic [AW-1:0]   cmp_base [NCMP];
  logic [EW-1:0]   cmp_exp  [NCMP];
  logic [NCMP-1:0] cmp_en;
  logic            clr_irq, cfg_acc, viol, trap, prot_any, cfg_wr, elevate;
  vkind_e          kind;

  assign cfg_wr  = cfg_acc && req_write;
  assign elevate = viol || trap;

  guard_regs #(.AW(AW), .DW(DW), .NCMP(NCMP), .EW(EW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(req_addr[3:0]),
    .cfg_data(req_wdata), .elevate(elevate), .mode_q(mode_q),
    .cmp_base(cmp_base), .cmp_exp(cmp_exp), .cmp_en(cmp_en),
    .clr_irq(clr_irq)
  );

  guard_decide #(
    .AW(AW), .NCMP(NCMP), .EW(EW), .CFG_BASE(CFG_BASE), .OLD_BASE(OLD_BASE),
    .NEW_BASE(NEW_BASE), .TRAP_BASE(TRAP_BASE), .BANK_LG(BANK_LG),
    .TRAP_LG(TRAP_LG)
  ) u_decide (
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .mode(mode_q), .cmp_base(cmp_base), .cmp_exp(cmp_exp), .cmp_en(cmp_en),
    .cfg_acc(cfg_acc), .pass(pass_en), .viol(viol), .trap(trap),
    .kind(kind), .prot_any(prot_any)
  );

  guard_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .viol(viol), .clr_irq(clr_irq),
    .addr(req_addr), .write(req_write), .mode(mode_q), .kind(kind),
    .irq_q(irq), .cap_addr(viol_addr), .cap_write(viol_write),
    .cap_mode(viol_mode), .cap_kind(viol_kind)
  );

  assign wake     = trap;
  assign cur_mode = mode_q;

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_en, wake, viol, cfg_acc}));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !pass_en && !wake && !viol);

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol && kind == VK_CFG |=> $stable(cmp_en));

  // R4
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && prot_any && mode_q != MODE_SUP |-> !pass_en);

endmodule

// File: tb/region_guard_test.sv
module region_guard_test;

  localparam logic [23:0] CFG = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        pass_en, wake, irq, viol_write;
  logic [1:0]  cur_mode, viol_mode, viol_kind;
  logic [23:0] viol_addr;

  int checks = 0;
  int errors = 0;
  logic s_pass, s_wake;

  always #5 clk = ~clk;

  region_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .pass_en(pass_en),
    .wake(wake), .cur_mode(cur_mode), .irq(irq), .viol_addr(viol_addr),
    .viol_write(viol_write), .viol_mode(viol_mode), .viol_kind(viol_kind)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // one request for one cycle; combinational outputs sampled mid-cycle
  task automatic access(input logic [23:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    #1;
    s_pass = pass_en;
    s_wake = wake;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  function automatic logic [31:0] cmp_word(input logic [23:0] b, input logic [4:0] e, input logic en);
    return {2'b00, en, e, b};
  endfunction

  task automatic set_mode(input logic [1:0] m);
    access(CFG + 24'd0, 1'b1, {30'd0, m});
    chk("R2 mode write", {30'd0, cur_mode}, {30'd0, m});
  endtask

  task automatic clear_irq();
    access(CFG + 24'd1, 1'b1, 32'd0);
    chk("R7 clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic escape();  // trap write to get back to supervisor
    access(24'hDF0410, 1'b1, 32'd0);
    chk("R8 escape", {30'd0, cur_mode}, 32'd2);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", {30'd0, cur_mode}, 32'd2);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 kind", {30'd0, viol_kind}, 32'd0);
    chk("R1 idle pass", {31'd0, pass_en}, 32'd0);
    chk("R1 idle wake", {31'd0, wake}, 32'd0);
  endtask

  task automatic t_setup();
    access(CFG + 24'd8, 1'b1, cmp_word(24'h100000, 5'd16, 1'b1));
    chk("R2 cfg no pass", {31'd0, s_pass}, 32'd0);
    access(CFG + 24'd9, 1'b1, cmp_word(24'h200000, 5'd12, 1'b0));
    access(CFG + 24'd10, 1'b1, cmp_word(24'h300005, 5'd0, 1'b1));
    access(24'h108000, 1'b0, 32'd0);
    chk("R4 supervisor passes", {31'd0, s_pass}, 32'd1);
    access(24'h000100, 1'b1, 32'd0);
    chk("R9 plain pass", {31'd0, s_pass}, 32'd1);
  endtask

  task automatic t_prot();
    set_mode(2'b00);
    access(24'h108000, 1'b1, 32'd0);
    chk("R4 blocked", {31'd0, s_pass}, 32'd0);
    chk("R7 irq", {31'd0, irq}, 32'd1);
    chk("R7 addr", {8'd0, viol_addr}, 32'h108000);
    chk("R7 write", {31'd0, viol_write}, 32'd1);
    chk("R7 mode", {30'd0, viol_mode}, 32'd0);
    chk("R4 kind", {30'd0, viol_kind}, 32'd2);
    chk("R8 elevated", {30'd0, cur_mode}, 32'd2);
    clear_irq();
  endtask

  task automatic t_bounds();
    set_mode(2'b00);
    access(24'h0FFFFF, 1'b0, 32'd0);
    chk("R3 below", {31'd0, s_pass}, 32'd1);
    access(24'h110000, 1'b0, 32'd0);
    chk("R3 above", {31'd0, s_pass}, 32'd1);
    access(24'h200010, 1'b0, 32'd0);
    chk("R3 disabled", {31'd0, s_pass}, 32'd1);
    access(24'h300004, 1'b0, 32'd0);
    chk("R3 byte neighbour", {31'd0, s_pass}, 32'd1);
    access(24'h300005, 1'b0, 32'd0);
    chk("R3 single byte", {31'd0, s_pass}, 32'd0);
    chk("R3 irq", {31'd0, irq}, 32'd1);
    chk("R3 addr", {8'd0, viol_addr}, 32'h300005);
    clear_irq();
  endtask

  task automatic t_chip();
    set_mode(2'b00);
    access(24'hDF0000, 1'b0, 32'd0);
    chk("R5 old legacy", {31'd0, s_pass}, 32'd1);
    access(24'hDF1004, 1'b0, 32'd0);
    chk("R5 new legacy", {31'd0, s_pass}, 32'd0);
    chk("R5 kind", {30'd0, viol_kind}, 32'd3);
    clear_irq();
    set_mode(2'b01);
    access(24'hDF1004, 1'b1, 32'd0);
    chk("R5 new mid", {31'd0, s_pass}, 32'd1);
    access(24'h100000, 1'b0, 32'd0);
    chk("R4 mid blocked", {31'd0, s_pass}, 32'd0);
    chk("R4 mid mode", {30'd0, viol_mode}, 32'd1);
    chk("R4 mid kind", {30'd0, viol_kind}, 32'd2);
    clear_irq();
  endtask

  task automatic t_trap();
    set_mode(2'b00);
    access(24'hDF0410, 1'b1, 32'd0);
    chk("R6 wake", {31'd0, s_wake}, 32'd1);
    chk("R6 dropped", {31'd0, s_pass}, 32'd0);
    chk("R6 no irq", {31'd0, irq}, 32'd0);
    chk("R8 trap elevates", {30'd0, cur_mode}, 32'd2);
    set_mode(2'b00);
    access(24'hDF0410, 1'b0, 32'd0);
    chk("R6 read pass", {31'd0, s_pass}, 32'd1);
    chk("R6 read no wake", {31'd0, s_wake}, 32'd0);
    escape();
    access(24'hDF0410, 1'b1, 32'd0);
    chk("R6 sup write pass", {31'd0, s_pass}, 32'd1);
    chk("R6 sup no wake", {31'd0, s_wake}, 32'd0);
  endtask

  task automatic t_cfg_lock();
    set_mode(2'b00);
    access(CFG + 24'd9, 1'b1, cmp_word(24'h200000, 5'd12, 1'b1));
    chk("R10 blocked", {31'd0, s_pass}, 32'd0);
    chk("R10 kind", {30'd0, viol_kind}, 32'd1);
    clear_irq();
    set_mode(2'b00);
    access(24'h200010, 1'b0, 32'd0);
    chk("R10 comparator unchanged", {31'd0, s_pass}, 32'd1);
    escape();
  endtask

  task automatic t_hold();
    set_mode(2'b00);
    access(24'h108000, 1'b0, 32'd0);
    set_mode(2'b01);
    access(24'h100004, 1'b1, 32'd0);
    chk("R7 second blocked", {31'd0, s_pass}, 32'd0);
    chk("R7 held addr", {8'd0, viol_addr}, 32'h108000);
    chk("R7 held write", {31'd0, viol_write}, 32'd0);
    chk("R7 held mode", {30'd0, viol_mode}, 32'd0);
    chk("R7 still irq", {31'd0, irq}, 32'd1);
    clear_irq();
  endtask

  task automatic t_mode11();
    access(CFG + 24'd0, 1'b1, 32'd3);
    chk("R2 code 3 ignored", {30'd0, cur_mode}, 32'd2);
    chk("R1 mode legal", {31'd0, cur_mode != 2'b11}, 32'd1);
  endtask

  task automatic t_idle();
    set_mode(2'b00);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 24'h108000; req_write = 1'b1;
    repeat (3) begin
      #1;
      chk("R9 idle pass", {31'd0, pass_en}, 32'd0);
      chk("R9 idle wake", {31'd0, wake}, 32'd0);
      @(negedge clk);
    end
    req_write = 1'b0;
    chk("R9 idle no irq", {31'd0, irq}, 32'd0);
    chk("R9 idle mode kept", {30'd0, cur_mode}, 32'd0);
    escape();
  endtask

  initial begin
    t_reset();
    t_setup();
    t_prot();
    t_bounds();
    t_chip();
    t_trap();
    t_cfg_lock();
    t_hold();
    t_mode11();
    t_idle();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule